// File: doc/BRIEF.md
# Host Bus Register Slave

This block is a register-access slave that sits on a processor's external bus. The bus has a 10-bit address, active-low chip select, write enable and output enable, and a wait line. Each host bus cycle becomes exactly one read or one write of a small internal byte-addressed register array. All of that work runs on the internal system clock. The array stands in for the real register file of the chip.

Two capture modes are selected by a strap.

- **Synchronous mode.** Address and direction are caught on the first rising edge of the bus clock that sees chip select low. That capture is then handed to the system clock.
- **Asynchronous mode.** Chip select passes through a two-flop synchronizer in the system clock. The address is taken in the cycle where the falling edge is detected.

The data width can be 8, 16 or 32 bits. The width decides which low address bits are dropped and which byte lanes take part. A second strap sets the active level of the wait line. The block also produces the enables the pad ring uses for the data bus and the wait line.

Top module: `hbus_slave`

## Requirements
- R1: While `rst_n` is low, `data_oe` and `wait_oe` are low and any cycle in progress is dropped. After reset, every register byte reads zero.
- R2: With `sync_mode`=0, `cs_n` is synchronized through two `sys_clk` flops. Each falling edge starts exactly one access, and the address and direction are sampled in that detection cycle.
- R3: With `sync_mode`=1, the address and direction are captured on the first rising `bus_clk` edge with `cs_n` low. Address changes after that edge, within the same assertion, have no effect.
- R4: `width_sel` encoding is 2'b00 = 8-bit, 2'b01 = 16-bit, 2'b10 = 32-bit, and 2'b11 acts as 32-bit. In 16-bit mode address bit 0 is ignored. In 32-bit mode address bits 1:0 are ignored. In 8-bit mode every address bit selects a byte.
- R5: Byte lane k (`data[8k+7:8k]`) maps to aligned address + k.
  - For 8-bit cycles only lane 0 takes part; for 16-bit cycles lanes 0 and 1 take part.
  - Lanes that do not take part read as zero, and their write data is ignored.
- R6: While `cs_n` is low and the access has not finished, `wait_o` is at its active level: high if `wait_pol`=1, low if `wait_pol`=0. Once read data is valid or write data is taken, `wait_o` goes to the inactive level and stays there until `cs_n` rises.
- R7: `wait_oe` is high exactly while `cs_n` is low and reset is released.
- R8: `data_oe` is high exactly while `cs_n` and `oe_n` are low, `we_n` is high and reset is released.
- R9: A write commits once per `cs_n` assertion, using the `data_in` value present when the access completes. Later changes of `data_in` while `cs_n` stays low are ignored.
- R10: After a read completes, `data_out` holds its value for as long as `cs_n` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | Internal system clock |
| bus_clk | input | 1 | Host bus clock, used in synchronous mode |
| rst_n | input | 1 | Active-low hardware reset, asynchronous |
| sync_mode | input | 1 | Strap: 1 = synchronous capture, 0 = asynchronous |
| wait_pol | input | 1 | Strap: active level of `wait_o` |
| width_sel | input | 2 | Data width: 00 = 8, 01 = 16, 1x = 32 bits |
| host_addr | input | 10 | Host address |
| cs_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| data_in | input | 32 | Write data from the host |
| data_out | output | 32 | Read data to the host |
| data_oe | output | 1 | Data-bus driver enable |
| wait_o | output | 1 | Wait line level |
| wait_oe | output | 1 | Wait-line driver enable |

## Verification
The bench changes the address after the first bus-clock edge in synchronous mode. A design that samples the address late would then write or read the wrong location.

It writes with garbage in unused upper lanes and with unaligned addresses in each width. Wrong masking shows up as corrupted neighbouring bytes or non-zero unused lanes.

It holds chip select low long after completion and changes the write data meanwhile. A slave that commits twice would store the late value, and an unstable read register would change `data_out`.

A reset in the middle of a write checks that the outputs release the bus and that the array comes back cleared.

// File: rtl/hbus_pkg.sv
package hbus_pkg;

   typedef enum logic [1:0] {
      BW_BYTE = 2'b00,
      BW_HALF = 2'b01,
      BW_WORD = 2'b10
   } bus_width_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_LAT,
      ST_DONE
   } acc_state_e;

   // byte lanes taking part in a cycle of the given width
   function automatic logic [3:0] lane_mask(input logic [1:0] w);
      case (w)
         BW_BYTE: lane_mask = 4'b0001;
         BW_HALF: lane_mask = 4'b0011;
         default: lane_mask = 4'b1111;
      endcase
   endfunction

   // low address bits dropped for the given width
   function automatic logic [1:0] drop_bits(input logic [1:0] w);
      case (w)
         BW_BYTE: drop_bits = 2'b00;
         BW_HALF: drop_bits = 2'b01;
         default: drop_bits = 2'b11;
      endcase
   endfunction

endpackage

// File: rtl/hbus_sync_edge.sv
module hbus_sync_edge #(
   parameter int   STAGES    = 2,
   parameter logic RST_VAL   = 1'b1,
   parameter bit   FALL_ONLY = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q,
   output logic pulse
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hbus_sync_edge: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain <= {STAGES{RST_VAL}};
         prev  <= RST_VAL;
      end else begin
         chain <= {chain[STAGES-2:0], d};
         prev  <= chain[STAGES-1];
      end
   end

   assign q = chain[STAGES-1];

   if (FALL_ONLY) begin : g_fall
      assign pulse = prev & ~q;
   end else begin : g_any
      assign pulse = prev ^ q;
   end

endmodule

// File: rtl/hbus_bclk_capture.sv
module hbus_bclk_capture #(
   parameter int ADDR_W = 10
) (
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] addr_cap,
   output logic              we_cap,
   output logic              tog
);

   logic cs_seen;

   always_ff @(posedge bus_clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_seen  <= 1'b0;
         addr_cap <= '0;
         we_cap   <= 1'b1;
         tog      <= 1'b0;
      end else begin
         cs_seen <= ~cs_n;
         if (!cs_n && !cs_seen) begin
            addr_cap <= addr;
            we_cap   <= we_n;
            tog      <= ~tog;
         end
      end
   end

endmodule

// File: rtl/hbus_regfile.sv
module hbus_regfile #(
   parameter int ADDR_W = 10,
   parameter int LANES  = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  base_addr,
   input  logic [LANES-1:0]   lane_en,
   input  logic               wr_en,
   input  logic [8*LANES-1:0] wdata,
   output logic [8*LANES-1:0] rdata
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
      end else if (wr_en) begin
         for (int l = 0; l < LANES; l++) begin
            if (lane_en[l]) mem[base_addr + ADDR_W'(l)] <= wdata[8*l +: 8];
         end
      end
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign rdata[8*g +: 8] = lane_en[g] ? mem[base_addr | ADDR_W'(g)] : 8'h00;
   end

endmodule

// File: rtl/hbus_slave.sv
module hbus_slave
   import hbus_pkg::*;
#(
   parameter int ADDR_W      = 10,
   parameter int DATA_W      = 32,
   parameter int SYNC_STAGES = 2,
   parameter int ACC_LAT     = 3
) (
   input  logic              sys_clk,
   input  logic              bus_clk,
   input  logic              rst_n,
   input  logic              sync_mode,
   input  logic              wait_pol,
   input  logic [1:0]        width_sel,
   input  logic [ADDR_W-1:0] host_addr,
   input  logic              cs_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [DATA_W-1:0] data_in,
   output logic [DATA_W-1:0] data_out,
   output logic              data_oe,
   output logic              wait_o,
   output logic              wait_oe
);

   localparam int LANES = DATA_W / 8;
   localparam int CNT_W = $clog2(ACC_LAT + 1);

   if (DATA_W != 32) begin : g_bad_width
      $error("hbus_slave: DATA_W must be 32 for the 8/16/32 width modes");
   end
   if (ACC_LAT < 1) begin : g_bad_lat
      $error("hbus_slave: ACC_LAT must be at least 1");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("hbus_slave: ADDR_W must be at least 2");
   end

   // asynchronous capture path
   logic cs_q, cs_fall;
   hbus_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1), .FALL_ONLY(1'b1)) u_cs_sync (
      .clk(sys_clk), .rst_n(rst_n), .d(cs_n), .q(cs_q), .pulse(cs_fall)
   );

   // synchronous capture path
   logic [ADDR_W-1:0] addr_cap;
   logic              we_cap, tog, tog_q, tog_pulse;
   hbus_bclk_capture #(.ADDR_W(ADDR_W)) u_bcap (
      .bus_clk(bus_clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n),
      .addr(host_addr), .addr_cap(addr_cap), .we_cap(we_cap), .tog(tog)
   );
   hbus_sync_edge #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0), .FALL_ONLY(1'b0)) u_tog_sync (
      .clk(sys_clk), .rst_n(rst_n), .d(tog), .q(tog_q), .pulse(tog_pulse)
   );

   logic              start;
   logic [ADDR_W-1:0] src_addr;
   logic              src_we;

   always_comb begin
      if (sync_mode) begin
         start    = tog_pulse;
         src_addr = addr_cap;
         src_we   = we_cap;
      end else begin
         start    = cs_fall;
         src_addr = host_addr;
         src_we   = we_n;
      end
   end

   // access sequencer
   acc_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic              we_q;
   logic [LANES-1:0]  lanes_q;
   logic [DATA_W-1:0] rd_q, rdata;
   logic              last, wr_en;

   assign last  = (cnt == CNT_W'(ACC_LAT - 1));
   assign wr_en = (state == ST_LAT) && last && !we_q;

   always_ff @(posedge sys_clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         cnt     <= '0;
         addr_q  <= '0;
         we_q    <= 1'b1;
         lanes_q <= '0;
         rd_q    <= '0;
      end else begin
         case (state)
            ST_IDLE: begin
               if (start) begin
                  addr_q  <= src_addr & ~{{(ADDR_W-2){1'b0}}, drop_bits(width_sel)};
                  we_q    <= src_we;
                  lanes_q <= LANES'(lane_mask(width_sel));
                  cnt     <= '0;
                  state   <= ST_LAT;
               end
            end
            ST_LAT: begin
               if (last) begin
                  if (we_q) rd_q <= rdata;
                  state <= ST_DONE;
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DONE: begin
               if (cs_q) state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   hbus_regfile #(.ADDR_W(ADDR_W), .LANES(LANES)) u_regs (
      .clk(sys_clk), .rst_n(rst_n), .base_addr(addr_q), .lane_en(lanes_q),
      .wr_en(wr_en), .wdata(data_in), .rdata(rdata)
   );

   // pad-side controls
   logic cyc, busy;
   assign cyc      = rst_n && !cs_n;
   assign busy     = (state != ST_DONE);
   assign wait_oe  = cyc;
   assign wait_o   = (cyc && busy) ? wait_pol : ~wait_pol;
   assign data_oe  = cyc && !oe_n && we_n;
   assign data_out = rd_q;

endmodule

// File: rtl/hbus_slave_chk.sv
module hbus_slave_chk #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cs_n,
   input logic              we_n,
   input logic              wait_pol,
   input logic              wait_o,
   input logic              wait_oe,
   input logic              data_oe,
   input logic [DATA_W-1:0] data_out,
   input logic              start,
   input logic              wr_en,
   input logic              in_done
);

   logic [1:0] wr_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      wr_cnt <= '0;
      else if (cs_n)   wr_cnt <= '0;
      else if (wr_en && wr_cnt != 2'b11) wr_cnt <= wr_cnt + 1'b1;
   end

   always_comb begin
      if (!rst_n) assert_reset_hiz_R1: assert (!wait_oe && !data_oe);
   end

   assert_start_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !start);

   assert_one_commit_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !cs_n) |-> (wr_cnt == 2'b00));

   assert_wait_hiz_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |-> !wait_oe);

   assert_data_dir_R8: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> (!cs_n && we_n));

   assert_done_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (in_done && wait_oe) |-> (wait_o == !wait_pol));

   assert_hold_data_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (in_done && $past(in_done)) |-> $stable(data_out));

endmodule

bind hbus_slave hbus_slave_chk #(.DATA_W(DATA_W)) u_chk (
   .clk(sys_clk), .rst_n(rst_n), .cs_n(cs_n), .we_n(we_n), .wait_pol(wait_pol),
   .wait_o(wait_o), .wait_oe(wait_oe), .data_oe(data_oe), .data_out(data_out),
   .start(start), .wr_en(wr_en), .in_done(state == hbus_pkg::ST_DONE)
);

// File: tb/hbus_slave_test.sv
module hbus_slave_test;

   logic        sys_clk = 1'b0;
   logic        bus_clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sync_mode = 1'b0;
   logic        wait_pol = 1'b1;
   logic [1:0]  width_sel = 2'b10;
   logic [9:0]  host_addr = '0;
   logic        cs_n = 1'b1;
   logic        we_n = 1'b1;
   logic        oe_n = 1'b1;
   logic [31:0] data_in = '0;
   logic [31:0] data_out;
   logic        data_oe, wait_o, wait_oe;

   int   total = 0;
   int   bad = 0;
   bit   ended = 1'b0;
   logic [7:0] model [1024];

   always #2 sys_clk = ~sys_clk;
   always #6 bus_clk = ~bus_clk;

   hbus_slave uut (
      .sys_clk(sys_clk), .bus_clk(bus_clk), .rst_n(rst_n), .sync_mode(sync_mode),
      .wait_pol(wait_pol), .width_sel(width_sel), .host_addr(host_addr),
      .cs_n(cs_n), .we_n(we_n), .oe_n(oe_n), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe), .wait_o(wait_o), .wait_oe(wait_oe)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   function automatic int nlanes(input logic [1:0] w);
      return (w == 2'b00) ? 1 : (w == 2'b01) ? 2 : 4;
   endfunction

   function automatic int align(input logic [9:0] a, input logic [1:0] w);
      return int'(a) - (int'(a) % nlanes(w));
   endfunction

   function automatic logic [31:0] mread(input logic [9:0] a, input logic [1:0] w);
      logic [31:0] r = '0;
      for (int l = 0; l < nlanes(w); l++) r[8*l +: 8] = model[align(a, w) + l];
      return r;
   endfunction

   task automatic mwrite(input logic [9:0] a, input logic [1:0] w, input logic [31:0] d);
      for (int l = 0; l < nlanes(w); l++) model[align(a, w) + l] = d[8*l +: 8];
   endtask

   task automatic mclear();
      for (int i = 0; i < 1024; i++) model[i] = 8'h00;
   endtask

   // every clock: pad enables against the R7 / R8 rules
   always @(negedge sys_clk) begin
      if (!ended) begin
         check(data_oe === (rst_n && !cs_n && !oe_n && we_n), "R8 data_oe",
               {31'd0, data_oe}, {31'd0, rst_n && !cs_n && !oe_n && we_n});
         check(wait_oe === (rst_n && !cs_n), "R7 wait_oe",
               {31'd0, wait_oe}, {31'd0, rst_n && !cs_n});
      end
   end

   task automatic bus_cycle(input bit wr, input logic [9:0] a, input logic [31:0] d,
                            input bit swap, input logic [9:0] a2, input int hold,
                            input logic [31:0] d2, output logic [31:0] q);
      int n;
      @(posedge sys_clk); #1;
      host_addr = a; data_in = d; we_n = !wr; oe_n = wr; cs_n = 1'b0;
      if (swap) begin
         @(posedge bus_clk); #1;
         host_addr = a2;
      end
      @(negedge sys_clk);
      check(wait_oe && wait_o === wait_pol, "R6 wait active at start",
            {31'd0, wait_o}, {31'd0, wait_pol});
      n = 0;
      while (wait_o === wait_pol && n < 60) begin
         @(negedge sys_clk);
         n++;
      end
      check(n >= 2 && n < 60, "R6 wait released after access", n, 32'd0);
      q = data_out;
      if (hold > 0) begin
         #1 data_in = d2;
         repeat (hold) @(negedge sys_clk);
         check(data_out === q, "R10 read data held", data_out, q);
         check(wait_o === !wait_pol, "R6 wait stays inactive", {31'd0, wait_o},
               {31'd0, !wait_pol});
      end
      #1;
      cs_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
      repeat (5) @(negedge sys_clk);
   endtask

   task automatic do_write(input logic [9:0] a, input logic [31:0] d);
      logic [31:0] q;
      bus_cycle(1'b1, a, d, 1'b0, '0, 0, '0, q);
      mwrite(a, width_sel, d);
   endtask

   task automatic do_read(input logic [9:0] a, input string req);
      logic [31:0] q;
      bus_cycle(1'b0, a, '0, 1'b0, '0, 0, '0, q);
      check(q === mread(a, width_sel), req, q, mread(a, width_sel));
   endtask

   initial begin
      repeat (100000) @(posedge sys_clk);
      total++;
      bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      finish_run();
   end

   initial begin
      logic [31:0] q;
      mclear();
      // R1: reset state
      repeat (3) @(negedge sys_clk);
      check(!data_oe && !wait_oe, "R1 enables low in reset", {30'd0, data_oe, wait_oe}, 0);
      #1 rst_n = 1'b1;
      repeat (3) @(negedge sys_clk);
      do_read(10'h000, "R1 zero after reset");
      do_read(10'h3FC, "R1 zero after reset top");

      // R2 / R4: asynchronous, 32-bit, unaligned address
      do_write(10'h01F, 32'hA1B2C3D4);
      do_read(10'h01C, "R4 32-bit aligned read");
      do_read(10'h01E, "R4 32-bit low bits ignored");

      // R5: 16-bit with junk in upper lanes
      width_sel = 2'b01;
      do_write(10'h041, 32'h1234BEEF);
      do_read(10'h040, "R5 16-bit lanes");
      width_sel = 2'b10;
      do_read(10'h040, "R5 upper lanes untouched");

      // R4 / R5: 8-bit
      width_sel = 2'b00;
      do_write(10'h043, 32'hFFFFFF5A);
      do_read(10'h043, "R4 8-bit byte");
      do_read(10'h042, "R4 8-bit neighbour");
      width_sel = 2'b11;
      do_read(10'h041, "R4 width code 11 as 32-bit");

      // R6: inverted wait polarity
      wait_pol = 1'b0;
      width_sel = 2'b10;
      do_write(10'h080, 32'h0BADF00D);
      do_read(10'h080, "R6 low polarity access");
      wait_pol = 1'b1;

      // R9 / R10: long hold, data changes after commit
      bus_cycle(1'b1, 10'h0C0, 32'h11223344, 1'b0, '0, 8, 32'hDEADBEEF, q);
      mwrite(10'h0C0, 2'b10, 32'h11223344);
      do_read(10'h0C0, "R9 single commit");
      bus_cycle(1'b0, 10'h0C0, '0, 1'b0, '0, 8, '0, q);
      check(q === 32'h11223344, "R10 long read", q, 32'h11223344);

      // R3: synchronous capture, address swapped after first bus edge
      sync_mode = 1'b1;
      bus_cycle(1'b1, 10'h104, 32'hCAFE0001, 1'b1, 10'h300, 0, '0, q);
      mwrite(10'h104, 2'b10, 32'hCAFE0001);
      do_read(10'h104, "R3 sync write to captured address");
      do_read(10'h300, "R3 swapped address untouched");
      bus_cycle(1'b0, 10'h01C, '0, 1'b1, 10'h0C0, 0, '0, q);
      check(q === mread(10'h01C, 2'b10), "R3 sync read uses captured address",
            q, mread(10'h01C, 2'b10));
      sync_mode = 1'b0;

      // R1: reset during a write
      @(posedge sys_clk); #1;
      host_addr = 10'h200; data_in = 32'h55AA55AA; we_n = 1'b0; oe_n = 1'b1; cs_n = 1'b0;
      repeat (2) @(negedge sys_clk);
      #1 rst_n = 1'b0;
      @(negedge sys_clk);
      check(!data_oe && !wait_oe, "R1 enables low on reset mid-cycle",
            {30'd0, data_oe, wait_oe}, 0);
      #1;
      cs_n = 1'b1; we_n = 1'b1;
      repeat (2) @(negedge sys_clk);
      #1 rst_n = 1'b1;
      mclear();
      repeat (3) @(negedge sys_clk);
      do_read(10'h200, "R1 aborted write not stored");
      do_read(10'h01C, "R1 registers cleared");

      finish_run();
   end

endmodule